// File: doc/BRIEF.md
# Two-Wire Bus Start/Stop Condition Detector

This block watches the clock and data lines of an open-drain two-wire bus from inside a fast synchronous system clock domain. Each raw line is first brought into the system clock domain through a chain of synchronizing flops. It then passes through a glitch filter. The filter accepts a new level only after that level has been held for a programmable number of consecutive system clock cycles. The filter window is a parameter, so one design serves both standard-mode and fast-mode buses. It is sized as the noise suppression time divided by the system clock period.

From the two filtered lines the block produces one-cycle event pulses for the protocol logic that follows: clock rising edge, clock falling edge, start condition, repeated start condition and stop condition. It also brings out the filtered data level. A data transition counts as a start or stop only when the filtered clock was high both before and at the data edge. Any other data transition is ordinary data. A start that arrives after a start and before the matching stop also raises the repeated-start pulse, in the same cycle as the normal start pulse.

Top module: `tw_cond_detect`

## Requirements
- R1: After reset, with both raw lines high, the filtered data level is 1 and no event pulse is raised.
- R2: A raw level that stays stable for FILTER_CYCLES consecutive samples is accepted. Its effect (level change or event pulse) becomes visible SYNC_STAGES + FILTER_CYCLES clock cycles after the raw change.
- R3: A raw pulse on either line lasting fewer than FILTER_CYCLES samples is ignored: no event is raised and the filtered data level does not move.
- R4: Each accepted clock transition gives exactly one one-cycle pulse: scl_rise for low-to-high and scl_fall for high-to-low.
- R5: A filtered data transition from 1 to 0 while the filtered clock is high raises start_pulse for one cycle.
- R6: A filtered data transition from 0 to 1 while the filtered clock is high raises stop_pulse for one cycle.
- R7: A data transition while the filtered clock is low raises neither start_pulse nor stop_pulse.
- R8: A start that arrives after a start and before a stop raises rstart_pulse together with start_pulse. A start that arrives after reset or after a stop raises start_pulse alone.
- R9: A data edge that is accepted in the same cycle as a clock rising edge is not classed as a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_raw | input | 1 | Raw bus clock line |
| sda_raw | input | 1 | Raw bus data line |
| sda_level | output | 1 | Filtered data level |
| scl_rise | output | 1 | One-cycle pulse on filtered clock rising edge |
| scl_fall | output | 1 | One-cycle pulse on filtered clock falling edge |
| start_pulse | output | 1 | One-cycle pulse on start or repeated start |
| rstart_pulse | output | 1 | One-cycle pulse on a start inside an open transfer |
| stop_pulse | output | 1 | One-cycle pulse on stop |

## Verification
The bench builds the block with FILTER_CYCLES = 4 and SYNC_STAGES = 2. With a window this small, pulses of exactly three and exactly four samples can be driven to probe both sides of the acceptance threshold. The six-cycle end-to-end latency can be counted edge by edge. Full start, repeated start and stop sequences also fit in a few hundred cycles. Driving both raw lines in the same cycle exercises the case where a clock edge and a data edge are accepted together.

// File: rtl/tw_cond_pkg.sv
package tw_cond_pkg;

   // bit positions of the two lines inside the per-line vectors
   localparam int unsigned LINE_SCL = 0;
   localparam int unsigned LINE_SDA = 1;
   localparam int unsigned N_LINES  = 2;

   // bus idle level of an open-drain line
   localparam logic IDLE_LEVEL = 1'b1;

   typedef struct packed {
      logic start;
      logic rstart;
      logic stop;
      logic rise;
      logic fall;
   } tw_evt_t;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int unsigned STAGES = 2,
   parameter logic        INIT   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tw_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{INIT}};
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/tw_glitch_filter.sv
module tw_glitch_filter #(
   parameter int unsigned WINDOW = 10,
   parameter logic        INIT   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (WINDOW < 1) begin : g_bad_window
      $error("tw_glitch_filter: WINDOW must be at least 1");
   end

   if (WINDOW == 1) begin : g_pass
      // single-sample window: plain register, no counter needed
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dout <= INIT;
         else        dout <= din;
      end
   end else begin : g_count
      localparam int unsigned CNT_W = $clog2(WINDOW);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

      logic [CNT_W-1:0] run_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dout  <= INIT;
            run_q <= '0;
         end else if (din == dout) begin
            run_q <= '0;
         end else if (run_q == LAST) begin
            dout  <= din;
            run_q <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/tw_cond_classify.sv
module tw_cond_classify
   import tw_cond_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_f,
   input  logic    sda_f,
   output tw_evt_t evt
);

   logic scl_d, sda_d, busy_q;
   logic scl_held_hi, sda_fell, sda_rose;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d  <= IDLE_LEVEL;
         sda_d  <= IDLE_LEVEL;
         busy_q <= 1'b0;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
         if (evt.start)     busy_q <= 1'b1;
         else if (evt.stop) busy_q <= 1'b0;
      end
   end

   always_comb begin
      // clock must be high in the previous and the current filtered cycle
      scl_held_hi = scl_f & scl_d;
      sda_fell    = sda_d & ~sda_f;
      sda_rose    = ~sda_d & sda_f;
      evt.start   = sda_fell & scl_held_hi;
      evt.stop    = sda_rose & scl_held_hi;
      evt.rstart  = evt.start & busy_q;
      evt.rise    = scl_f & ~scl_d;
      evt.fall    = ~scl_f & scl_d;
   end

endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect
   import tw_cond_pkg::*;
#(
   parameter int unsigned FILTER_CYCLES = 10,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   output logic sda_level,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_pulse,
   output logic rstart_pulse,
   output logic stop_pulse
);

   if (FILTER_CYCLES < 1) begin : g_bad_filter
      $error("tw_cond_detect: FILTER_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tw_cond_detect: SYNC_STAGES must be at least 2");
   end

   logic [N_LINES-1:0] raw_vec, sync_vec, filt_vec;
   logic    sda_sync;
   tw_evt_t evt;

   assign raw_vec[LINE_SCL] = scl_raw;
   assign raw_vec[LINE_SDA] = sda_raw;

   for (genvar g = 0; g < N_LINES; g++) begin : g_line
      tw_sync #(
         .STAGES (SYNC_STAGES),
         .INIT   (IDLE_LEVEL)
      ) i_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .din   (raw_vec[g]),
         .dout  (sync_vec[g])
      );

      tw_glitch_filter #(
         .WINDOW (FILTER_CYCLES),
         .INIT   (IDLE_LEVEL)
      ) i_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .din   (sync_vec[g]),
         .dout  (filt_vec[g])
      );
   end

   assign sda_sync = sync_vec[LINE_SDA];

   tw_cond_classify i_class (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_f (filt_vec[LINE_SCL]),
      .sda_f (filt_vec[LINE_SDA]),
      .evt   (evt)
   );

   assign sda_level    = filt_vec[LINE_SDA];
   assign scl_rise     = evt.rise;
   assign scl_fall     = evt.fall;
   assign start_pulse  = evt.start;
   assign rstart_pulse = evt.rstart;
   assign stop_pulse   = evt.stop;

endmodule

// File: rtl/tw_cond_detect_chk.sv
module tw_cond_detect_chk #(
   parameter int unsigned FILTER_CYCLES = 10
) (
   input logic clk,
   input logic rst_n,
   input logic sda_sync,
   input logic sda_level,
   input logic scl_rise,
   input logic scl_fall,
   input logic start_pulse,
   input logic rstart_pulse,
   input logic stop_pulse
);

   // consecutive cycles the synchronized data has disagreed with the filtered level
   int unsigned mism_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    mism_cnt <= 0;
      else if (sda_sync == sda_level) mism_cnt <= 0;
      else if (mism_cnt < FILTER_CYCLES) mism_cnt <= mism_cnt + 1;
   end

   // R2
   filter_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_level) |-> $past(mism_cnt) + 1 >= FILTER_CYCLES);

   // R4
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scl_rise |=> !scl_rise);

   // R4
   fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scl_fall |=> !scl_fall);

   // R5
   start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> (!sda_level && $past(sda_level)));

   // R6
   stop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse |-> (sda_level && !$past(sda_level)));

   // R8
   rstart_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rstart_pulse |-> start_pulse);

   // R9
   no_cond_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scl_rise |-> !(start_pulse || stop_pulse));

endmodule

bind tw_cond_detect tw_cond_detect_chk #(
   .FILTER_CYCLES (FILTER_CYCLES)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sda_sync     (sda_sync),
   .sda_level    (sda_level),
   .scl_rise     (scl_rise),
   .scl_fall     (scl_fall),
   .start_pulse  (start_pulse),
   .rstart_pulse (rstart_pulse),
   .stop_pulse   (stop_pulse)
);

// File: tb/test_tw_cond_detect.sv
`timescale 1ns/1ps
module test_tw_cond_detect;

   localparam int unsigned FC = 4;
   localparam int unsigned SS = 2;
   localparam int unsigned SETTLE = FC + SS + 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_raw = 1'b1;
   logic sda_raw = 1'b1;
   logic sda_level, scl_rise, scl_fall, start_pulse, rstart_pulse, stop_pulse;

   int n_checks = 0;
   int n_fails  = 0;
   int c_start = 0, c_rstart = 0, c_stop = 0, c_rise = 0, c_fall = 0, c_lvl_lo = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tw_cond_detect #(
      .FILTER_CYCLES (FC),
      .SYNC_STAGES   (SS)
   ) i_tw_cond_detect (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_raw      (scl_raw),
      .sda_raw      (sda_raw),
      .sda_level    (sda_level),
      .scl_rise     (scl_rise),
      .scl_fall     (scl_fall),
      .start_pulse  (start_pulse),
      .rstart_pulse (rstart_pulse),
      .stop_pulse   (stop_pulse)
   );

   // event counters sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         c_start  += int'(start_pulse);
         c_rstart += int'(rstart_pulse);
         c_stop   += int'(stop_pulse);
         c_rise   += int'(scl_rise);
         c_fall   += int'(scl_fall);
         c_lvl_lo += int'(!sda_level);
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_counts();
      c_start = 0; c_rstart = 0; c_stop = 0; c_rise = 0; c_fall = 0; c_lvl_lo = 0;
   endtask

   task automatic set_lines(input logic scl, input logic sda);
      @(negedge clk);
      scl_raw = scl;
      sda_raw = sda;
      repeat (SETTLE) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   endtask

   // R1: idle after reset
   task automatic t_reset();
      clear_counts();
      repeat (SETTLE) @(negedge clk);
      chk("R1 sda_level", int'(sda_level), 1);
      chk("R1 events", c_start + c_stop + c_rise + c_fall + c_rstart, 0);
   endtask

   // R2, R4: latency and single pulse of a clock fall and rise
   task automatic t_latency();
      int lat;
      clear_counts();
      lat = 0;
      @(negedge clk);
      scl_raw = 1'b0;
      for (int i = 1; i <= 20; i++) begin
         @(negedge clk);
         if (scl_fall && lat == 0) lat = i;
      end
      chk("R2 fall latency", lat, FC + SS);
      chk("R4 one fall pulse", c_fall, 1);
      lat = 0;
      @(negedge clk);
      scl_raw = 1'b1;
      for (int i = 1; i <= 20; i++) begin
         @(negedge clk);
         if (scl_rise && lat == 0) lat = i;
      end
      chk("R2 rise latency", lat, FC + SS);
      chk("R4 one rise pulse", c_rise, 1);
   endtask

   // R3: short pulses ignored; R2/R5/R6: exact-window pulse accepted
   task automatic t_glitch();
      clear_counts();
      @(negedge clk);
      sda_raw = 1'b0;
      repeat (FC - 1) @(negedge clk);
      sda_raw = 1'b1;
      repeat (SETTLE) @(negedge clk);
      chk("R3 sda glitch level", c_lvl_lo, 0);
      chk("R3 sda glitch start", c_start + c_stop, 0);
      @(negedge clk);
      scl_raw = 1'b0;
      repeat (FC - 1) @(negedge clk);
      scl_raw = 1'b1;
      repeat (SETTLE) @(negedge clk);
      chk("R3 scl glitch", c_fall + c_rise, 0);
      clear_counts();
      @(negedge clk);
      sda_raw = 1'b0;
      repeat (FC) @(negedge clk);
      sda_raw = 1'b1;
      repeat (SETTLE) @(negedge clk);
      chk("R5 start on window pulse", c_start, 1);
      chk("R6 stop on window pulse", c_stop, 1);
      chk("R2 level followed window pulse", c_lvl_lo, int'(FC));
   endtask

   // R7: data change while clock low
   task automatic t_data();
      clear_counts();
      set_lines(1'b0, 1'b1);
      set_lines(1'b0, 1'b0);
      set_lines(1'b1, 1'b0);
      set_lines(1'b0, 1'b0);
      set_lines(1'b0, 1'b1);
      set_lines(1'b1, 1'b1);
      chk("R7 no start/stop", c_start + c_stop, 0);
      chk("R4 rise count", c_rise, 2);
      chk("R4 fall count", c_fall, 2);
   endtask

   // R8: repeated start inside a transfer
   task automatic t_rstart();
      clear_counts();
      set_lines(1'b1, 1'b0);
      chk("R8 first start", c_start, 1);
      chk("R8 first not repeated", c_rstart, 0);
      set_lines(1'b0, 1'b0);
      set_lines(1'b0, 1'b1);
      set_lines(1'b1, 1'b1);
      set_lines(1'b1, 1'b0);
      chk("R8 second start", c_start, 2);
      chk("R8 repeated start", c_rstart, 1);
      set_lines(1'b0, 1'b0);
      set_lines(1'b1, 1'b0);
      set_lines(1'b1, 1'b1);
      chk("R6 stop", c_stop, 1);
      set_lines(1'b1, 1'b0);
      chk("R8 start after stop", c_start, 3);
      chk("R8 not repeated after stop", c_rstart, 1);
      set_lines(1'b1, 1'b1);
   endtask

   // R9: data and clock edges accepted in the same cycle
   task automatic t_coincide();
      set_lines(1'b0, 1'b1);
      clear_counts();
      set_lines(1'b1, 1'b0);
      chk("R9 rise seen", c_rise, 1);
      chk("R9 no start", c_start + c_stop, 0);
      set_lines(1'b1, 1'b1);
      chk("R6 stop after coincide", c_stop, 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_latency();
      t_glitch();
      t_data();
      t_rstart();
      t_coincide();
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule